// File: doc/BRIEF.md
# Scan Chain with Built-In Flush Self-Test

This block is a single chain of multiplexed scan flops around a small piece of next-state logic, with a sequencer that proves the chain can shift before any scan patterns are trusted. A test-control input picks the mode of every cell. At 1 each cell captures the output of the combinational logic. At 0 each cell takes the bit held by its upstream neighbour. The first cell takes its bit from a serial input pin, and the last cell drives a serial output pin.

A one-cycle start request launches the flush sequencer. For N+4 clocks it replaces the serial input with a repeating 0,0,1,1 stream, so every cell sees both steady values and both edges. The sequencer skips the first N output bits, which only show the chain's latency. It then compares each later output bit with the bit it injected N clocks before. Any mismatch sets a fail flag that stays set, and a one-cycle done pulse marks the end of the sequence. The step counter is sized for a full scan session of up to MAX_VECS vectors, (MAX_VECS+2)·N + MAX_VECS + 4 clocks.

Top module: `scan_flush_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every cell, scan_out, busy, done and fail read 0.
- R2: With tc=1 each clock loads state_out with state_out rotated left by one (bit N-1 moves to bit 0) XOR func_in. scan_in has no effect in this mode.
- R3: With tc=0 each clock moves cell i-1 into cell i and loads cell 0 with the serial input. scan_out always equals cell N-1, so a bit on scan_in reaches scan_out N clocks later.
- R4: When start is high at a clock, busy is high from the next cycle for N+4 cycles. While busy, cell 0 is fed flush bit k = bit 1 of k (0,0,1,1,…) in step k = 0..N+3, and the scan_in pin is ignored.
- R5: done is high for exactly one cycle, in the cycle right after the last flush step, and busy is low in that cycle.
- R6: In steps k = N..N+3 the sequencer compares scan_out with flush bit k-N. With tc=0 during the whole flush, fail stays 0.
- R7: A mismatch, for example from holding tc=1 during a flush, sets fail. fail stays set until a later start clears it on the next clock.
- R8: A start that arrives while busy restarts the sequence at step 0, and done then follows N+4 cycles after the new start.
- R9: After a clean flush with tc=0, cell i holds flush bit N+3-i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for every cell, not gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| tc | input | 1 | Test control: 1 capture, 0 shift |
| scan_in | input | 1 | Serial input to cell 0 when no flush is running |
| func_in | input | N | Functional inputs to the next-state logic |
| start | input | 1 | Synchronous request to start or restart the flush |
| scan_out | output | 1 | Serial output, the value of cell N-1 |
| state_out | output | N | Parallel view of all cells |
| busy | output | 1 | A flush is in progress |
| done | output | 1 | One-cycle pulse when the flush ends |
| fail | output | 1 | Sticky flag: the flush found a mismatch |

## Verification
Cells, busy, done and fail are all registered, so each one shows the effect of the inputs present at a clock edge one cycle later. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge, so each result is read in the cycle it becomes due. Serial data and flush bits take N cycles to travel from cell 0 to scan_out. done is due N+4 cycles after the start edge, and fail settles by that same edge. The bench's cycle model counts these latencies from the requirements, and explicit checks sample done, fail and the final chain contents at exactly those cycles.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic {
        MODE_SHIFT   = 1'b0,
        MODE_CAPTURE = 1'b1
    } cell_mode_e;

endpackage

// File: rtl/scan_logic.sv
module scan_logic #(
    parameter int N = 8
) (
    input  logic [N-1:0] state,
    input  logic [N-1:0] func_in,
    output logic [N-1:0] nxt
);
    // next state: rotate left by one, then mix in the functional inputs
    always_comb begin
        nxt = {state[N-2:0], state[N-1]} ^ func_in;
    end
endmodule

// File: rtl/scan_chain.sv
module scan_chain
    import scan_pkg::*;
#(
    parameter int N = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  cell_mode_e mode,
    input  logic       si,
    input  logic [N-1:0] cap_d,
    output logic [N-1:0] q,
    output logic       so
);
    typedef struct packed {
        logic [N-1:0] cells;
    } chain_t;

    chain_t       chain_q;
    chain_t       chain_d;
    logic [N-1:0] ser;
    logic [N-1:0] cell_d;

    // serial neighbour of each cell: cell 0 sees si, cell i sees cell i-1
    assign ser = {chain_q.cells[N-2:0], si};

    for (genvar i = 0; i < N; i++) begin : gen_cell
        assign cell_d[i] = (mode == MODE_CAPTURE) ? cap_d[i] : ser[i];
    end

    always_comb begin
        chain_d       = chain_q;
        chain_d.cells = cell_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q  = chain_q.cells;
    assign so = chain_q.cells[N-1];
endmodule

// File: rtl/flush_seq.sv
module flush_seq #(
    parameter int N     = 8,
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic so,
    output logic pat,
    output logic busy,
    output logic done,
    output logic fail
);
    localparam logic [CNT_W-1:0] LAT  = CNT_W'(N);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N + 3);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             fail;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_q;
    seq_t seq_d;
    logic exp_bit;

    // flush bit k is bit 1 of k; the bit due now was injected LAT steps ago
    assign exp_bit = ((seq_q.cnt - LAT) & CNT_W'(2)) != '0;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (start) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = '0;
            seq_d.fail = 1'b0;
        end else if (seq_q.busy) begin
            if (seq_q.cnt >= LAT && so != exp_bit) seq_d.fail = 1'b1;
            if (seq_q.cnt == LAST) begin
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
                seq_d.cnt  = '0;
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign pat  = (seq_q.cnt & CNT_W'(2)) != '0;
    assign busy = seq_q.busy;
    assign done = seq_q.done;
    assign fail = seq_q.fail;
endmodule

// File: rtl/scan_flush_top.sv
module scan_flush_top
    import scan_pkg::*;
#(
    parameter int N        = 8,
    parameter int MAX_VECS = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tc,
    input  logic         scan_in,
    input  logic [N-1:0] func_in,
    input  logic         start,
    output logic         scan_out,
    output logic [N-1:0] state_out,
    output logic         busy,
    output logic         done,
    output logic         fail
);
    // counter covers a full session: (C+2)*N + C + 4 clocks
    localparam int SESSION = (MAX_VECS + 2) * N + MAX_VECS + 4;
    localparam int CNT_W   = $clog2(SESSION + 1) < 2 ? 2 : $clog2(SESSION + 1);

    logic [N-1:0] nxt;
    logic         pat;
    logic         si_sel;

    scan_logic #(.N(N)) u_logic (
        .state   (state_out),
        .func_in (func_in),
        .nxt     (nxt)
    );

    // the flush stream replaces the pin while the sequencer runs
    assign si_sel = busy ? pat : scan_in;

    scan_chain #(.N(N)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (cell_mode_e'(tc)),
        .si    (si_sel),
        .cap_d (nxt),
        .q     (state_out),
        .so    (scan_out)
    );

    flush_seq #(.N(N), .CNT_W(CNT_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .so    (scan_out),
        .pat   (pat),
        .busy  (busy),
        .done  (done),
        .fail  (fail)
    );
endmodule

// File: rtl/scan_flush_chk.sv
module scan_flush_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tc,
    input logic         start,
    input logic [N-1:0] func_in,
    input logic [N-1:0] state_out,
    input logic         busy,
    input logic         done,
    input logic         fail
);
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> state_out == ({$past(state_out[N-2:0]), $past(state_out[N-1])} ^ $past(func_in)));

    a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !tc |=> state_out[N-1:1] == $past(state_out[N-2:0]));

    a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);

    a_r7_fail_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !fail);
endmodule

bind scan_flush_top scan_flush_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tc        (tc),
    .start     (start),
    .func_in   (func_in),
    .state_out (state_out),
    .busy      (busy),
    .done      (done),
    .fail      (fail)
);

// File: tb/sim_scan_flush_top.sv
`timescale 1ns/1ps
module sim_scan_flush_top;
    localparam int N     = 8;
    localparam int FLUSH = N + 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         tc;
    logic         scan_in;
    logic [N-1:0] func_in;
    logic         start;
    logic         scan_out;
    logic [N-1:0] state_out;
    logic         busy;
    logic         done;
    logic         fail;

    always #2.5 clk = ~clk;

    scan_flush_top #(.N(N), .MAX_VECS(16)) u0 (
        .clk(clk), .rst_n(rst_n), .tc(tc), .scan_in(scan_in), .func_in(func_in),
        .start(start), .scan_out(scan_out), .state_out(state_out),
        .busy(busy), .done(done), .fail(fail)
    );

    int checks = 0;
    int errors = 0;

    // bench model, built from the requirements
    logic [N-1:0] m_st;
    logic         m_busy, m_done, m_fail;
    int           m_k;

    function automatic logic fbit(int k);
        return ((k >> 1) & 1) == 1;
    endfunction

    function automatic logic [N-1:0] cap_next(logic [N-1:0] s, logic [N-1:0] f);
        return {s[N-2:0], s[N-1]} ^ f;
    endfunction

    function automatic logic [N-1:0] flushed_image();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = fbit(N + 3 - i);
        return v;
    endfunction

    task automatic check(string tag, logic [N+3:0] act, logic [N+3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, {state_out, scan_out, busy, done, fail},
                   {m_st, m_st[N-1], m_busy, m_done, m_fail});
    endtask

    task automatic step(string tag, logic tcv, logic siv, logic stv, logic [N-1:0] fiv);
        logic [N-1:0] n_st;
        logic         n_busy, n_done, n_fail, si_eff;
        int           n_k;
        @(negedge clk);
        tc = tcv; scan_in = siv; start = stv; func_in = fiv;
        n_busy = m_busy; n_fail = m_fail; n_done = 1'b0; n_k = m_k;
        if (stv) begin
            n_busy = 1'b1; n_k = 0; n_fail = 1'b0;
        end else if (m_busy) begin
            if (m_k >= N && m_st[N-1] != fbit(m_k - N)) n_fail = 1'b1;
            if (m_k == N + 3) begin
                n_busy = 1'b0; n_done = 1'b1; n_k = 0;
            end else n_k = m_k + 1;
        end
        si_eff = m_busy ? fbit(m_k) : siv;
        n_st   = tcv ? cap_next(m_st, fiv) : {m_st[N-2:0], si_eff};
        @(posedge clk);
        #1;
        m_st = n_st; m_busy = n_busy; m_done = n_done; m_fail = n_fail; m_k = n_k;
        check_all(tag);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; tc = 1'b0; scan_in = 1'b0; start = 1'b0; func_in = '0;
        m_st = '0; m_busy = 0; m_done = 0; m_fail = 0; m_k = 0;
        repeat (3) @(posedge clk);
        #1 check_all("R1 in reset");
        @(negedge clk) rst_n = 1'b1;
        #1 check_all("R1 after reset");

        // R2: capture mode, random functional inputs, serial pin must not matter
        for (int i = 0; i < 40; i++)
            step("R2", 1'b1, 1'($urandom), 1'b0, N'($urandom));

        // R3: shift mode, random serial data, functional inputs must not matter
        for (int i = 0; i < 40; i++)
            step("R3", 1'b0, 1'($urandom), 1'b0, N'($urandom));

        // R4/R5/R6/R9: clean flush, serial pin randomised (ignored)
        step("R4 start", 1'b0, 1'($urandom), 1'b1, '0);
        for (int i = 0; i < FLUSH; i++)
            step("R4 flush", 1'b0, 1'($urandom), 1'b0, N'($urandom));
        check("R5 done pulse", {N'(0), 1'b0, 1'b0, done, busy}, {N'(0), 1'b0, 1'b0, 1'b1, 1'b0});
        check("R6 no fail", {N'(0), 3'b000, fail}, '0);
        check("R9 final image", {state_out, 4'h0}, {flushed_image(), 4'h0});
        step("R5 done drops", 1'b0, 1'b0, 1'b0, '0);

        // R7: clear chain, then flush in capture mode with zero inputs
        for (int i = 0; i < N; i++) step("R7 clear", 1'b0, 1'b0, 1'b0, '0);
        step("R7 start", 1'b1, 1'b0, 1'b1, '0);
        for (int i = 0; i < FLUSH; i++) step("R7 flush", 1'b1, 1'b0, 1'b0, '0);
        check("R7 fail set", {N'(0), 2'b00, done, fail}, {N'(0), 2'b00, 1'b1, 1'b1});
        for (int i = 0; i < 5; i++) step("R7 sticky", 1'b1, 1'b0, 1'b0, '0);
        check("R7 still set", {N'(0), 3'b000, fail}, {N'(0), 3'b000, 1'b1});
        step("R7 clear by start", 1'b0, 1'b0, 1'b1, '0);
        check("R7 cleared", {N'(0), 3'b000, fail}, '0);
        for (int i = 0; i < FLUSH; i++) step("R6 flush", 1'b0, 1'($urandom), 1'b0, '0);
        check("R6 pass", {N'(0), 2'b00, done, fail}, {N'(0), 2'b00, 1'b1, 1'b0});

        // R8: restart mid-flush
        step("R8 start", 1'b0, 1'b0, 1'b1, '0);
        for (int i = 0; i < 3; i++) step("R8 early", 1'b0, 1'b0, 1'b0, '0);
        step("R8 restart", 1'b0, 1'b0, 1'b1, '0);
        for (int i = 0; i < FLUSH - 1; i++) step("R8 flush", 1'b0, 1'($urandom), 1'b0, '0);
        check("R8 not yet done", {N'(0), 2'b00, done, busy}, {N'(0), 2'b00, 1'b0, 1'b1});
        step("R8 last", 1'b0, 1'b0, 1'b0, '0);
        check("R8 done", {N'(0), 2'b00, done, fail}, {N'(0), 2'b00, 1'b1, 1'b0});
        check("R9 after restart", {state_out, 4'h0}, {flushed_image(), 4'h0});

        // mixed random traffic over every mode
        for (int i = 0; i < 300; i++)
            step("R2/R3/R4 mix", 1'($urandom), 1'($urandom),
                 ($urandom % 23) == 0, N'($urandom));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule